// File: doc/BRIEF.md
# Multi-Channel Timer Output Compare Unit

This block holds a 16-bit counter that advances on every clock and five 16-bit compare channels that watch it. When a channel's stored value equals the count, the channel raises its bit in a shared flag register. An interrupt line goes high while any raised flag has its enable bit set. Channels 2 to 5 each own one output pin and act on it through a two-bit action code. Channel 1 is a master channel. Its match can force any chosen subset of all five pins to programmed levels.

Software reaches the unit through a byte-wide register bus. Each 16-bit quantity is split into a high byte and a low byte. Reading the counter's high byte captures the low byte, so a high read followed by a low read gives one coherent count. Writing a compare register's high byte suspends that channel's compare for the following cycle. A value that is only half updated therefore never produces a false match. Pin actions are taken on every match, whether or not the flag has been cleared.

Top module: `oc_timer_unit`

## Requirements
- R1: The counter resets to 0 and rises by one on every clock, wrapping at 16 bits. A read of address 0x00 returns the count's high byte and captures its low byte in the same cycle. A later read of address 0x01 returns that captured byte.
- R2: A channel matches in any cycle where its compare value equals the count. At the next clock edge its flag is set in the flag register at address 0x0F, where bit i-1 belongs to channel i.
- R3: `irq` is high exactly when some flag bit is set and the same bit is set in the interrupt enable register at address 0x10.
- R4: Writing the flag register clears every flag whose written bit is 1. A written 0 leaves its flag unchanged.
- R5: For channel k in 2..5, bits [2(k-2)+1 : 2(k-2)] of the action register at address 0x0E select what a match does to pin k-1. The codes are 00 no effect, 01 invert, 10 drive 0, 11 drive 1. The pin changes at the edge that sets the flag.
- R6: A pin action is taken on every match, including when that channel's flag is still set from an earlier match.
- R7: A channel 1 match sets each pin p whose bit p is 1 in the master mask register (address 0x0C) to bit p of the master data register (address 0x0D). Pins with a 0 mask bit are left alone. Bits 7:5 of both registers read as 0.
- R8: When channel 1 and another channel match in the same cycle and both affect a pin, the channel 1 data sets that pin.
- R9: Channel i's compare value sits at address 2i (high byte) and 2i+1 (low byte). It resets to 0xFFFF and reads back whatever was written, so it can serve as plain storage.
- R10: Writing a compare register's high byte blocks that channel's match in the next cycle, even if the count then equals the new value.
- R11: After reset all pins, flags, enables, the action register and the master registers are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (when `bus_sel` is high) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid in the cycle of the read |
| oc_pin | output | 5 | Compare output pins; bit p belongs to channel p+1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the one-cycle hold-off after a high-byte write. It only shows when the new compare value equals the count in exactly the cycle after that write. The bench reads the counter (high byte, then low byte) and gets a count C for a known cycle. It then issues the low-byte write and the high-byte write back to back, with the target set to C+4. That target is the count in the cycle right after the high-byte write, so a design without the hold-off would set the flag and drive the pin. The same count-relative scheme places master and ordinary matches in one cycle to check pin priority.

// File: rtl/oc_pkg.sv
// Package oc_pkg
// Shared constants and types for the output compare unit.
// Assumes a fixed five-channel arrangement: channel 1 is the master,
// channels 2..5 each own one pin.
package oc_pkg;

    localparam int NCH        = 5;
    localparam int ACT_W      = 2 * (NCH - 1);

    // Register addresses (byte offsets on the register bus)
    localparam int A_CNT_HI   = 0;
    localparam int A_CNT_LO   = 1;
    localparam int A_CMP_BASE = 2;   // channel i high byte at 2i, low at 2i+1
    localparam int A_MMASK    = 12;
    localparam int A_MDATA    = 13;
    localparam int A_ACT      = 14;
    localparam int A_FLAG     = 15;
    localparam int A_IEN      = 16;

    // Action taken on a pin by channels 2..5
    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

endpackage

// File: rtl/oc_free_counter.sv
// Module oc_free_counter
// Free-running counter of two bus bytes, plus a capture register for the
// low byte. The capture is loaded when software reads the high byte, so a
// following low-byte read gives a value coherent with that high byte.
// Assumes the counter advances on every clock (no prescaler).
module oc_free_counter #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_hi,
    output logic [2*DATA_W-1:0]   count,
    output logic [DATA_W-1:0]     lo_hold
);

    localparam int CNT_W = 2 * DATA_W;

    // Advance the count by one every clock
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CNT_W'(1);
    end

    // Capture the low byte whenever the high byte is read
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold <= '0;
        else if (rd_hi) lo_hold <= count[DATA_W-1:0];
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> count == $past(count) + CNT_W'(1));

    assert_lo_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> lo_hold == $past(count[DATA_W-1:0]));

endmodule

// File: rtl/oc_cmp_channel.sv
// Module oc_cmp_channel
// One compare channel: a 16-bit register written a byte at a time, and an
// equality check against the counter. A high-byte write sets a one-cycle
// hold-off so that a pair of byte writes cannot match on a half-new value.
// Assumes the bus never writes both bytes in the same cycle.
module oc_cmp_channel #(
    parameter int                  DATA_W    = 8,
    parameter logic [2*DATA_W-1:0] RESET_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_hi,
    input  logic                  we_lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   count,
    output logic [2*DATA_W-1:0]   value,
    output logic                  match
);

    logic hold_off;

    // Store the compare value byte by byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RESET_VAL;
        end else begin
            if (we_hi) value[2*DATA_W-1:DATA_W] <= wdata;
            if (we_lo) value[DATA_W-1:0]        <= wdata;
        end
    end

    // Block the compare for the cycle after a high-byte write
    always_ff @(posedge clk) begin
        if (!rst_n) hold_off <= 1'b0;
        else        hold_off <= we_hi;
    end

    // Equality against the running count, unless held off
    assign match = (count == value) && !hold_off;

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> !match);

    assert_hi_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> value[2*DATA_W-1:DATA_W] == $past(wdata));

endmodule

// File: rtl/oc_pin_ctrl.sv
// Module oc_pin_ctrl
// Holds the compare output pins. Channels 1..NPIN-1 (index k) act on pin k
// through their two-bit code. The master channel (index 0) then overrides
// every pin selected by its mask with its data bit, so it wins any conflict.
// Assumes match bits are single-cycle equality results.
module oc_pin_ctrl import oc_pkg::*; #(
    parameter int NPIN = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPIN-1:0]         match,
    input  logic [2*(NPIN-1)-1:0]   act_ctrl,
    input  logic [NPIN-1:0]         mmask,
    input  logic [NPIN-1:0]         mdata,
    output logic [NPIN-1:0]         pins
);

    logic [NPIN-1:0] pins_nxt;

    // Combine per-channel actions, then apply the master override
    always_comb begin
        pins_nxt = pins;
        for (int k = 1; k < NPIN; k++) begin
            if (match[k]) begin
                unique case (act_e'(act_ctrl[2*(k-1) +: 2]))
                    ACT_TOGGLE: pins_nxt[k] = ~pins[k];
                    ACT_LOW:    pins_nxt[k] = 1'b0;
                    ACT_HIGH:   pins_nxt[k] = 1'b1;
                    default:    pins_nxt[k] = pins[k];
                endcase
            end
        end
        if (match[0]) pins_nxt = (pins_nxt & ~mmask) | (mdata & mmask);
    end

    // Register the pins
    always_ff @(posedge clk) begin
        if (!rst_n) pins <= '0;
        else        pins <= pins_nxt;
    end

    assert_master_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match[0] |=> (pins & $past(mmask)) == ($past(mdata) & $past(mmask)));

    assert_quiet_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |=> $stable(pins));

endmodule

// File: rtl/oc_timer_unit.sv
// Module oc_timer_unit
// Top of the output compare unit: register bus decode, flag and enable
// registers, action and master registers, the counter, five compare
// channels and the pin controller.
// Assumes single-cycle bus accesses; read data is combinational.
module oc_timer_unit import oc_pkg::*; #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NCH-1:0]      oc_pin,
    output logic                irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic                 wr_en, rd_en;
    logic [CNT_W-1:0]     count;
    logic [DATA_W-1:0]    lo_hold;
    logic [CNT_W-1:0]     cmp_val [NCH];
    logic [NCH-1:0]       match;
    logic [NCH-1:0]       we_hi, we_lo;
    logic [NCH-1:0]       flags, irq_en, mmask, mdata;
    logic [ACT_W-1:0]     act_ctrl;
    logic [NCH-1:0]       clr_mask;

    assign wr_en = bus_sel &&  bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    oc_free_counter #(.DATA_W(DATA_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_hi   (rd_en && bus_addr == ADDR_W'(A_CNT_HI)),
        .count   (count),
        .lo_hold (lo_hold)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign we_hi[g] = wr_en && bus_addr == ADDR_W'(A_CMP_BASE + 2*g);
        assign we_lo[g] = wr_en && bus_addr == ADDR_W'(A_CMP_BASE + 2*g + 1);

        oc_cmp_channel #(.DATA_W(DATA_W), .RESET_VAL('1)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .we_hi (we_hi[g]),
            .we_lo (we_lo[g]),
            .wdata (bus_wdata),
            .count (count),
            .value (cmp_val[g]),
            .match (match[g])
        );
    end

    // Control registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= '0;
            mmask    <= '0;
            mdata    <= '0;
            act_ctrl <= '0;
        end else if (wr_en) begin
            if (bus_addr == ADDR_W'(A_IEN))   irq_en   <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(A_MMASK)) mmask    <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(A_MDATA)) mdata    <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(A_ACT))   act_ctrl <= bus_wdata[ACT_W-1:0];
        end
    end

    // Flag bits cleared by a written 1
    assign clr_mask = (wr_en && bus_addr == ADDR_W'(A_FLAG)) ? bus_wdata[NCH-1:0] : '0;

    // Flags: a new match wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | match;
    end

    assign irq = |(flags & irq_en);

    oc_pin_ctrl #(.NPIN(NCH)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .act_ctrl (act_ctrl),
        .mmask    (mmask),
        .mdata    (mdata),
        .pins     (oc_pin)
    );

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CNT_HI)) bus_rdata = count[CNT_W-1:DATA_W];
        if (bus_addr == ADDR_W'(A_CNT_LO)) bus_rdata = lo_hold;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_CMP_BASE + 2*i))     bus_rdata = cmp_val[i][CNT_W-1:DATA_W];
            if (bus_addr == ADDR_W'(A_CMP_BASE + 2*i + 1)) bus_rdata = cmp_val[i][DATA_W-1:0];
        end
        if (bus_addr == ADDR_W'(A_MMASK)) bus_rdata = DATA_W'(mmask);
        if (bus_addr == ADDR_W'(A_MDATA)) bus_rdata = DATA_W'(mdata);
        if (bus_addr == ADDR_W'(A_ACT))   bus_rdata = DATA_W'(act_ctrl);
        if (bus_addr == ADDR_W'(A_FLAG))  bus_rdata = DATA_W'(flags);
        if (bus_addr == ADDR_W'(A_IEN))   bus_rdata = DATA_W'(irq_en);
    end

    assert_flag_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> (flags & $past(match)) == $past(match));

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    assert_zero_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(A_FLAG) && bus_wdata == '0) |=>
        (flags & $past(flags)) == $past(flags));

    assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (bus_addr == ADDR_W'(A_MMASK) || bus_addr == ADDR_W'(A_MDATA)))
        |-> bus_rdata[DATA_W-1:NCH] == '0);

endmodule

// File: tb/test_oc_timer_unit.sv
`timescale 1ns/1ps
module test_oc_timer_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] oc_pin;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    oc_timer_unit i_oc_timer_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .oc_pin(oc_pin), .irq(irq)
    );

    // {action code for channel 2, expected pin 1 after its match}; flag is never cleared between rows
    localparam logic [2:0] VEC [8] = '{3'b111, 3'b010, 3'b011, 3'b100,
                                       3'b000, 3'b111, 3'b001, 3'b100};

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Each bus task starts at a falling edge and ends at the next one
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic get_count(output logic [15:0] c);
        logic [7:0] h, l;
        rd(5'd0, h);
        rd(5'd1, l);
        c = {h, l};
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        wr(5'(2*ch), v[15:8]);
        wr(5'(2*ch + 1), v[7:0]);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b, h1, l1, h2, l2;
        logic [15:0] c, t;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R11 reset state; R9 compare reset value
        chk("R11 pins", 16'(oc_pin), 16'h0);
        chk("R11 irq", 16'(irq), 16'h0);
        rd(5'd15, b); chk("R11 flags", 16'(b), 16'h0);
        rd(5'd14, b); chk("R11 action reg", 16'(b), 16'h0);
        rd(5'd10, b); chk("R9 ch5 hi reset", 16'(b), 16'hFF);
        rd(5'd11, b); chk("R9 ch5 lo reset", 16'(b), 16'hFF);

        // R5 R6 table of channel 2 actions on pin 1
        foreach (VEC[i]) begin
            wr(5'd14, {6'b0, VEC[i][2:1]});
            get_count(c);
            set_cmp(2, c + 16'd30);
            idle(40);
            chk($sformatf("R5 R6 row %0d pin1", i), 16'(oc_pin[1]), 16'(VEC[i][0]));
        end

        // R2 flag set; R3 irq gating; R4 write-one-to-clear
        rd(5'd15, b); chk("R2 flag ch2", 16'(b), 16'h02);
        chk("R3 irq masked", 16'(irq), 16'h0);
        wr(5'd16, 8'h02);
        chk("R3 irq enabled", 16'(irq), 16'h1);
        wr(5'd15, 8'h00);
        rd(5'd15, b); chk("R4 zero write keeps flag", 16'(b), 16'h02);
        wr(5'd15, 8'h02);
        rd(5'd15, b); chk("R4 one write clears", 16'(b), 16'h00);
        chk("R3 irq after clear", 16'(irq), 16'h0);

        // R7 unimplemented bits; R7 R8 master override in same cycle as channel 2
        wr(5'd12, 8'hFF);
        rd(5'd12, b); chk("R7 mask readback", 16'(b), 16'h1F);
        wr(5'd12, 8'h03);
        wr(5'd13, 8'hE1);
        rd(5'd13, b); chk("R7 data readback", 16'(b), 16'h01);
        wr(5'd14, 8'h03);
        get_count(c);
        t = c + 16'd50;
        set_cmp(1, t);
        set_cmp(2, t);
        idle(60);
        chk("R7 R8 pins after master match", 16'(oc_pin), 16'h01);
        rd(5'd15, b); chk("R2 flags ch1 ch2", 16'(b), 16'h03);

        // R10 high-byte write holds off the compare for the next cycle
        wr(5'd14, 8'h0C);
        get_count(c);             // c is the count during the high-byte read
        t = c + 16'd4;            // count in the cycle right after the high-byte write
        wr(5'd7, t[7:0]);
        wr(5'd6, t[15:8]);
        idle(10);
        rd(5'd15, b); chk("R10 ch3 flag stays clear", 16'(b & 8'h04), 16'h0);
        chk("R10 pin2 unchanged", 16'(oc_pin[2]), 16'h0);

        // R1 coherent counter read across a gap
        rd(5'd0, h1);
        idle(5);
        rd(5'd1, l1);
        rd(5'd0, h2);
        rd(5'd1, l2);
        chk("R1 captured low byte", {h1, l1}, {h2, l2} - 16'd7);

        // R9 plain storage
        set_cmp(4, 16'h1234);
        rd(5'd8, b); chk("R9 ch4 hi", 16'(b), 16'h12);
        rd(5'd9, b); chk("R9 ch4 lo", 16'(b), 16'h34);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule